// File: doc/BRIEF.md
# Flash Program/Erase Staging Latch

This block stages program and erase operations on a behavioural flash store of 16-bit words and on a small set of shadow control bits. Software first writes a three-bit control register. While the latch bit is set, the next write on the array port does not perform a normal access. Instead it captures a target: one byte, one aligned word, or the shadow bits, together with a data pattern. Setting the pulse bit then applies the staged effect for as long as the pulse bit stays set. Clearing the pulse bit ends the pulse. The pulse duration and the number of pulses are left to software or to an outside sequencer. No high-voltage or analog timing is modelled.

An erased bit reads as 1. A program pulse can only clear bits, because each cycle it ANDs the stored word with the captured mask. An erase pulse sets every word and every shadow bit back to 1 at the same time. The combinational read port stays live at all times, so a verify read can follow each pulse without changing the control state.

Top module: `fpe_latch_ctl`

## Requirements
- R1: After reset, ctl_o is 0, pulse_o is 0, every word reads 16'hFFFF and shadow_o is all ones.
- R2: The control register bits are bit0 = latch, bit1 = erase-select and bit2 = pulse. The pulse bit always takes the written value. The latch and erase bits take the written value only when the pulse bit was 0 before the write, and are otherwise left unchanged.
- R3: An array-port write made while the latch bit is 0 changes no stored word, and a later pulse does not raise pulse_o.
- R4: An array-port write made while the latch bit is 1 and the pulse bit is 0 arms a target. pulse_o is 1 exactly when the pulse bit is set and a target is armed.
- R5: While a program pulse is active (erase bit 0), the target word becomes its old value ANDed with the captured data. No bit ever changes from 0 to 1 except through an erase.
- R6: A byte write (arr_word_i = 0) uses arr_wdata_i[7:0]. An even byte address selects bits 15:8 of the word and an odd byte address selects bits 7:0. The other lane is left unchanged.
- R7: A word write with arr_addr_i[0] = 1 is rejected and arms nothing.
- R8: An erase pulse (erase bit 1) sets every word to 16'hFFFF and every shadow bit to 1.
- R9: A captured write with arr_shd_i = 1 targets the shadow bits, which take their old value ANDed with arr_wdata_i[SHADOW_W-1:0] during the pulse.
- R10: While the latch bit is set, rd_data_o keeps returning the stored contents of the word at rd_idx_i.
- R11: Clearing the latch bit discards the armed target.
- R12: Array-port writes made while the pulse bit is set do not change the captured target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 3 | Control write data {pulse, erase, latch} |
| ctl_o | output | 3 | Current control bits |
| arr_we_i | input | 1 | Array port write strobe |
| arr_addr_i | input | ADDR_W | Byte address of the write |
| arr_word_i | input | 1 | 1 selects a word write, 0 selects a byte write |
| arr_shd_i | input | 1 | Selects the shadow bits as the target |
| arr_wdata_i | input | 16 | Write data |
| rd_idx_i | input | ADDR_W-1 | Word index of the read port |
| rd_data_o | output | 16 | Stored word at rd_idx_i |
| shadow_o | output | SHADOW_W | Shadow bits |
| pulse_o | output | 1 | Pulse active on an armed target |

## Verification
The bench uses the default ADDR_W = 5 and SHADOW_W = 8, which gives a 16-word store. With this size every word, both byte lanes and the shadow bits can be read back after each scenario, so an erase is checked on words that earlier scenarios programmed. The narrow shadow width allows an exact comparison of the AND result after a shadow pulse.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int unsigned DATA_W = 16;

  typedef struct packed {
    logic pulse;
    logic erase;
    logic latch;
  } ctl_t;
endpackage

// File: rtl/fpe_ctl_reg.sv
module fpe_ctl_reg
  import fpe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  ctl_t wdata_i,
  output ctl_t ctl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o <= '0;
    end else if (we_i) begin
      ctl_o.pulse <= wdata_i.pulse;
      // mode bits frozen while a pulse runs
      if (!ctl_o.pulse) begin
        ctl_o.latch <= wdata_i.latch;
        ctl_o.erase <= wdata_i.erase;
      end
    end
  end
endmodule

// File: rtl/fpe_tgt_latch.sv
module fpe_tgt_latch
  import fpe_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned IDX_W = ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctl_t              ctl_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_i,
  input  logic              shd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              armed_o,
  output logic              shd_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] mask_o
);
  logic              cap;
  logic              misaligned;
  logic [DATA_W-1:0] mask_d;

  assign misaligned = word_i && addr_i[0] && !shd_i;
  assign cap = we_i && ctl_i.latch && !ctl_i.pulse && !misaligned;

  always_comb begin
    if (word_i || shd_i) mask_d = wdata_i;
    else if (addr_i[0])  mask_d = {8'hFF, wdata_i[7:0]};
    else                 mask_d = {wdata_i[7:0], 8'hFF};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      shd_o   <= 1'b0;
      idx_o   <= '0;
      mask_o  <= '1;
    end else if (!ctl_i.latch) begin
      armed_o <= 1'b0;
    end else if (cap) begin
      armed_o <= 1'b1;
      shd_o   <= shd_i;
      idx_o   <= addr_i[ADDR_W-1:1];
      mask_o  <= mask_d;
    end
  end
endmodule

// File: rtl/fpe_store.sv
module fpe_store
  import fpe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned SHADOW_W = 8,
  localparam int unsigned IDX_W   = ADDR_W - 1,
  localparam int unsigned WORDS   = 1 << IDX_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                prog_i,
  input  logic                erase_i,
  input  logic                shd_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [DATA_W-1:0]   mask_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [SHADOW_W-1:0] shadow_o
);
  logic [DATA_W-1:0] mem [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        mem[i] <= '1;
      else if (erase_i)                                   mem[i] <= '1;
      else if (prog_i && !shd_i && idx_i == IDX_W'(i))    mem[i] <= mem[i] & mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              shadow_o <= '1;
    else if (erase_i)         shadow_o <= '1;
    else if (prog_i && shd_i) shadow_o <= shadow_o & mask_i[SHADOW_W-1:0];
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/fpe_latch_ctl.sv
module fpe_latch_ctl
  import fpe_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned SHADOW_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctl_we_i,
  input  logic [2:0]          ctl_wdata_i,
  output logic [2:0]          ctl_o,
  input  logic                arr_we_i,
  input  logic [ADDR_W-1:0]   arr_addr_i,
  input  logic                arr_word_i,
  input  logic                arr_shd_i,
  input  logic [15:0]         arr_wdata_i,
  input  logic [ADDR_W-2:0]   rd_idx_i,
  output logic [15:0]         rd_data_o,
  output logic [SHADOW_W-1:0] shadow_o,
  output logic                pulse_o
);
  localparam int unsigned IDX_W = ADDR_W - 1;

  ctl_t              ctl;
  logic              armed, tgt_shd;
  logic [IDX_W-1:0]  tgt_idx;
  logic [DATA_W-1:0] tgt_mask;

  fpe_ctl_reg u_ctl (
    .clk_i, .rst_ni,
    .we_i    (ctl_we_i),
    .wdata_i (ctl_t'(ctl_wdata_i)),
    .ctl_o   (ctl)
  );

  fpe_tgt_latch #(.ADDR_W(ADDR_W)) u_lat (
    .clk_i, .rst_ni,
    .ctl_i   (ctl),
    .we_i    (arr_we_i),
    .addr_i  (arr_addr_i),
    .word_i  (arr_word_i),
    .shd_i   (arr_shd_i),
    .wdata_i (arr_wdata_i),
    .armed_o (armed),
    .shd_o   (tgt_shd),
    .idx_o   (tgt_idx),
    .mask_o  (tgt_mask)
  );

  assign pulse_o = ctl.pulse && armed;
  assign ctl_o   = ctl;

  fpe_store #(.ADDR_W(ADDR_W), .SHADOW_W(SHADOW_W)) u_store (
    .clk_i, .rst_ni,
    .prog_i    (pulse_o && !ctl.erase),
    .erase_i   (pulse_o && ctl.erase),
    .shd_i     (tgt_shd),
    .idx_i     (tgt_idx),
    .mask_i    (tgt_mask),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .shadow_o  (shadow_o)
  );
endmodule

// File: rtl/fpe_latch_ctl_chk.sv
module fpe_latch_ctl_chk #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned SHADOW_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2:0]          ctl_o,
  input logic                pulse_o,
  input logic [ADDR_W-2:0]   rd_idx_i,
  input logic [15:0]         rd_data_o,
  input logic [SHADOW_W-1:0] shadow_o
);
  a_r4_pulse_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> ctl_o[2]);

  a_r2_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[2] |=> ctl_o[1:0] == $past(ctl_o[1:0]));

  a_r5_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_idx_i) && !$past(pulse_o && ctl_o[1]))
      |-> (rd_data_o & ~$past(rd_data_o)) == 16'h0);

  a_r9_shadow_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pulse_o && ctl_o[1]) |-> (shadow_o & ~$past(shadow_o)) == '0);

  a_r8_erase_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_o && ctl_o[1]) |=> (&shadow_o && rd_data_o == 16'hFFFF));
endmodule

bind fpe_latch_ctl fpe_latch_ctl_chk #(.ADDR_W(ADDR_W), .SHADOW_W(SHADOW_W)) u_chk (
  .clk_i, .rst_ni, .ctl_o, .pulse_o, .rd_idx_i, .rd_data_o, .shadow_o
);

// File: tb/fpe_latch_ctl_tb.sv
module fpe_latch_ctl_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned SHADOW_W   = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                ctl_we = 1'b0;
  logic [2:0]          ctl_wdata = '0;
  logic [2:0]          ctl;
  logic                arr_we = 1'b0;
  logic [ADDR_W-1:0]   arr_addr = '0;
  logic                arr_word = 1'b0;
  logic                arr_shd = 1'b0;
  logic [15:0]         arr_wdata = '0;
  logic [ADDR_W-2:0]   rd_idx = '0;
  logic [15:0]         rd_data;
  logic [SHADOW_W-1:0] shadow;
  logic                pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpe_latch_ctl #(.ADDR_W(ADDR_W), .SHADOW_W(SHADOW_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_o(ctl),
    .arr_we_i(arr_we), .arr_addr_i(arr_addr), .arr_word_i(arr_word),
    .arr_shd_i(arr_shd), .arr_wdata_i(arr_wdata),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data), .shadow_o(shadow), .pulse_o(pulse)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [2:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_arr(logic [ADDR_W-1:0] a, logic w, logic s, logic [15:0] d);
    @(negedge clk); arr_we = 1'b1; arr_addr = a; arr_word = w; arr_shd = s; arr_wdata = d;
    @(negedge clk); arr_we = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-2:0] i, string req, logic [15:0] exp);
    rd_idx = i; #1;
    check(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic pulse_run();
    wr_ctl(3'b101);
    check("R4 pulse active", 32'(pulse), 32'd1);
    repeat (2) @(negedge clk);
    wr_ctl(3'b001);
  endtask

  task automatic t_reset();
    check("R1 ctl", 32'(ctl), 32'd0);
    check("R1 pulse", 32'(pulse), 32'd0);
    rd(0, "R1 word0", 16'hFFFF);
    rd(15, "R1 word15", 16'hFFFF);
    check("R1 shadow", 32'(shadow), 32'hFF);
  endtask

  task automatic t_no_latch();
    wr_arr(5'd2, 1'b1, 1'b0, 16'h0000);
    wr_ctl(3'b100);
    check("R3 pulse off", 32'(pulse), 32'd0);
    rd(1, "R3 word1", 16'hFFFF);
    wr_ctl(3'b000);
  endtask

  task automatic t_word_prog();
    wr_ctl(3'b001);
    wr_arr(5'd4, 1'b1, 1'b0, 16'hA5C3);
    check("R4 armed no pulse", 32'(pulse), 32'd0);
    rd(2, "R10 verify before pulse", 16'hFFFF);
    pulse_run();
    rd(2, "R5 word program", 16'hA5C3);
    wr_arr(5'd4, 1'b1, 1'b0, 16'h0FF0);
    pulse_run();
    rd(2, "R5 and only", 16'h05C0);
  endtask

  task automatic t_freeze();
    wr_ctl(3'b101);
    wr_ctl(3'b111);
    check("R2 erase held", 32'(ctl), 32'b101);
    wr_ctl(3'b010);
    check("R2 pulse clears mode held", 32'(ctl), 32'b001);
    rd(2, "R2 no erase", 16'h05C0);
  endtask

  task automatic t_byte();
    wr_arr(5'd7, 1'b0, 1'b0, 16'hAB12);
    pulse_run();
    rd(3, "R6 odd lane", 16'hFF12);
    wr_arr(5'd6, 1'b0, 1'b0, 16'h0034);
    pulse_run();
    rd(3, "R6 even lane", 16'h3412);
  endtask

  task automatic t_misaligned();
    wr_ctl(3'b000);
    wr_ctl(3'b001);
    wr_arr(5'd9, 1'b1, 1'b0, 16'h0000);
    wr_ctl(3'b101);
    check("R7 not armed", 32'(pulse), 32'd0);
    wr_ctl(3'b001);
    rd(4, "R7 word4", 16'hFFFF);
  endtask

  task automatic t_pulse_capture();
    wr_arr(5'd10, 1'b1, 1'b0, 16'hF0F0);
    wr_ctl(3'b101);
    wr_arr(5'd10, 1'b1, 1'b0, 16'h0000);
    wr_ctl(3'b001);
    rd(5, "R12 capture held", 16'hF0F0);
  endtask

  task automatic t_shadow();
    wr_arr(5'd0, 1'b1, 1'b1, 16'h005A);
    pulse_run();
    check("R9 shadow", 32'(shadow), 32'h5A);
    rd(0, "R9 array untouched", 16'hFFFF);
  endtask

  task automatic t_clear_latch();
    wr_arr(5'd12, 1'b1, 1'b0, 16'h0000);
    wr_ctl(3'b000);
    wr_ctl(3'b100);
    check("R11 discarded", 32'(pulse), 32'd0);
    rd(6, "R11 word6", 16'hFFFF);
    wr_ctl(3'b000);
  endtask

  task automatic t_erase();
    wr_ctl(3'b011);
    wr_arr(5'd0, 1'b1, 1'b0, 16'h0000);
    wr_ctl(3'b111);
    check("R8 pulse", 32'(pulse), 32'd1);
    @(negedge clk);
    wr_ctl(3'b011);
    rd(2, "R8 word2", 16'hFFFF);
    rd(3, "R8 word3", 16'hFFFF);
    rd(5, "R8 word5", 16'hFFFF);
    check("R8 shadow", 32'(shadow), 32'hFF);
    wr_ctl(3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_latch();
    t_word_prog();
    t_freeze();
    t_byte();
    t_misaligned();
    t_pulse_capture();
    t_shadow();
    t_clear_latch();
    t_erase();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule